// File: doc/BRIEF.md
# Home-Node Coherence Directory Controller

This block is the directory kept at the home node of a distributed shared-memory machine. For each memory block homed here it stores a coherence state (Invalid, Shared or Exclusive) and a bit-vector of the nodes that hold a cached copy. Requesting nodes send it read, exclusive-ownership, writeback and invalidation-acknowledge messages. For each one it chooses a response. It may return data from home memory. It may redirect a read to the node that holds the block exclusively. It may send point-to-point invalidations to each other sharer and hold back the ownership grant until every acknowledgement has come back.

Requests arrive on a valid/ready channel and are handled one at a time. Responses leave on a registered valid/ready channel. A message is never broadcast: each outgoing message names exactly one destination node. While one ownership transfer is collecting acknowledgements, the block involved is locked. Conflicting requests receive a retry response rather than waiting in the controller. The directory array is cleared by a sweep after reset and is laid out so that it maps onto a single block RAM.

Top module: `coh_dir_home`

## Requirements
- R1: After reset, msg_valid is low and req_ready stays low for at most 2^BLK_AW + 3 cycles. After that every block reads as Invalid with no sharers.
- R2: A read (req_type 0) to a block in Invalid or Shared state produces one DATA message (msg_type 0) to the requester, and the requester is added as a sharer.
- R3: A read to a block held Exclusive by a different node produces one FORWARD message (msg_type 1) whose msg_dst is the owner and whose msg_src is the requester. Afterwards the block is Shared by both the former owner and the requester.
- R4: A read from the node that already holds the block Exclusive produces no message and leaves the directory unchanged.
- R5: An exclusive request (req_type 1) sends one INVALIDATE (msg_type 2) to every node recorded as a sharer other than the requester, in ascending node order, with msg_src set to the requester. No invalidation ever goes to the requester itself.
- R6: The GRANT (msg_type 3) to the requester is sent immediately when no other sharer exists. Otherwise it is sent only after a number of acknowledgements (req_type 3, same block) equal to the number of invalidations sent. After the grant, the block is Exclusive with the requester as its only sharer.
- R7: While acknowledgements are outstanding, any request to the locked block and any exclusive request to any block gets a BUSY message (msg_type 4) to the requester and changes nothing. An acknowledgement that does not name the locked block is ignored.
- R8: A writeback (req_type 2) from the Exclusive owner returns the block to Invalid with an empty sharer vector. A writeback from any other node is ignored.
- R9: Every message carries the requester in msg_src and the block in msg_blk. Once msg_valid is high, the message's fields stay unchanged until msg_ready is seen.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller accepts a request this cycle |
| req_type | input | 2 | 0 read, 1 exclusive, 2 writeback, 3 invalidation acknowledge |
| req_src | input | log2(N_NODES) | Node issuing the request |
| req_blk | input | BLK_AW | Block address |
| msg_valid | output | 1 | Outgoing message present |
| msg_ready | input | 1 | Network takes the message |
| msg_type | output | 3 | 0 data, 1 forward, 2 invalidate, 3 grant, 4 busy |
| msg_dst | output | log2(N_NODES) | Destination node |
| msg_src | output | log2(N_NODES) | Node on whose behalf the message is sent |
| msg_blk | output | BLK_AW | Block address |

## Verification
The hardest situation to reach is the locked window. An exclusive request must meet several sharers, and other traffic must then arrive between the invalidations and the last acknowledgement. The directed part builds a block with two sharers and then takes ownership of it. Before acknowledging, it sends a conflicting read, an exclusive request to a second block, a stray acknowledgement and an unrelated read. The random part keeps addresses within four blocks, so ownership transfers keep colliding. It answers only part of the outstanding invalidations between other requests, while msg_ready is held back at random to exercise stalls.

// File: rtl/coh_dir_pkg.sv
package coh_dir_pkg;
  // directory entry states
  localparam logic [1:0] DS_INV = 2'd0;
  localparam logic [1:0] DS_SHR = 2'd1;
  localparam logic [1:0] DS_EXC = 2'd2;
  // incoming request kinds
  localparam logic [1:0] RQ_READ  = 2'd0;
  localparam logic [1:0] RQ_EXCL  = 2'd1;
  localparam logic [1:0] RQ_WBACK = 2'd2;
  localparam logic [1:0] RQ_IACK  = 2'd3;
  // outgoing message kinds
  localparam logic [2:0] MS_DATA  = 3'd0;
  localparam logic [2:0] MS_FWD   = 3'd1;
  localparam logic [2:0] MS_INV   = 3'd2;
  localparam logic [2:0] MS_GRANT = 3'd3;
  localparam logic [2:0] MS_BUSY  = 3'd4;
endpackage

// File: rtl/coh_dir_store.sv
module coh_dir_store
  import coh_dir_pkg::*;
#(
  parameter int N_NODES = 4,
  parameter int BLK_AW  = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [BLK_AW-1:0]  rd_addr,
  output logic [1:0]         rd_state,
  output logic [N_NODES-1:0] rd_sharers,
  input  logic               we,
  input  logic [BLK_AW-1:0]  wr_addr,
  input  logic [1:0]         wr_state,
  input  logic [N_NODES-1:0] wr_sharers
);
  localparam int DEPTH = 1 << BLK_AW;
  localparam int EW    = N_NODES + 2;

  logic [EW-1:0] mem [DEPTH];
  logic [EW-1:0] rd_q;

  always_ff @(posedge clk) begin
    if (we) mem[wr_addr] <= {wr_state, wr_sharers};
    rd_q <= mem[rd_addr];
  end

  assign rd_state   = rd_q[EW-1 -: 2];
  assign rd_sharers = rd_q[N_NODES-1:0];

  a_r6_excl_single_owner: assert property (@(posedge clk) disable iff (rst)
    (we && wr_state == DS_EXC) |-> ($countones(wr_sharers) == 1));
  a_r8_invalid_empty: assert property (@(posedge clk) disable iff (rst)
    (we && wr_state == DS_INV) |-> (wr_sharers == '0));
  a_r2_shared_nonempty: assert property (@(posedge clk) disable iff (rst)
    (we && wr_state == DS_SHR) |-> (wr_sharers != '0));
endmodule

// File: rtl/coh_lowest_one.sv
module coh_lowest_one #(
  parameter int W  = 4,
  parameter int IW = (W > 1) ? $clog2(W) : 1
) (
  input  logic [W-1:0]  vec,
  output logic [IW-1:0] idx
);
  always_comb begin
    idx = '0;
    for (int i = W - 1; i >= 0; i--) begin
      if (vec[i]) idx = IW'(i);
    end
  end
endmodule

// File: rtl/coh_ack_counter.sv
module coh_ack_counter #(
  parameter int CW = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  input  logic          dec,
  output logic          last
);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)       cnt <= '0;
    else if (load) cnt <= load_val;
    else if (dec)  cnt <= cnt - 1'b1;
  end

  assign last = (cnt == CW'(1));

  a_r6_no_underflow: assert property (@(posedge clk) disable iff (rst)
    dec |-> (cnt != '0));
  a_r6_load_nonzero: assert property (@(posedge clk) disable iff (rst)
    load |-> (load_val != '0 && !dec));
endmodule

// File: rtl/coh_dir_home.sv
module coh_dir_home
  import coh_dir_pkg::*;
#(
  parameter int N_NODES = 4,
  parameter int BLK_AW  = 4,
  parameter int NID_W   = $clog2(N_NODES)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [1:0]        req_type,
  input  logic [NID_W-1:0]  req_src,
  input  logic [BLK_AW-1:0] req_blk,
  output logic              msg_valid,
  input  logic              msg_ready,
  output logic [2:0]        msg_type,
  output logic [NID_W-1:0]  msg_dst,
  output logic [NID_W-1:0]  msg_src,
  output logic [BLK_AW-1:0] msg_blk
);
  localparam int CNT_W = $clog2(N_NODES + 1);

  typedef enum logic [2:0] {S_INIT, S_IDLE, S_LOOK, S_SEND, S_INVS} fsm_e;
  fsm_e st;

  logic [BLK_AW-1:0]  init_ptr;
  logic [1:0]         cur_type;
  logic [NID_W-1:0]   cur_src;
  logic [BLK_AW-1:0]  cur_blk;
  logic               pend;
  logic [NID_W-1:0]   pend_src;
  logic [BLK_AW-1:0]  pend_blk;
  logic [N_NODES-1:0] inv_mask;

  logic [1:0]         rd_state;
  logic [N_NODES-1:0] rd_sh;
  logic               dir_we;
  logic [BLK_AW-1:0]  dir_waddr;
  logic [1:0]         dir_wstate;
  logic [N_NODES-1:0] dir_wsh;

  logic [N_NODES-1:0] reqbit, others;
  logic [CNT_W-1:0]   others_cnt;
  logic [NID_W-1:0]   owner_idx, inv_idx;
  logic               acc, ack_hit, ack_last, ack_load, is_exc, req_owns;

  logic               mv_q;
  logic [2:0]         mt_q;
  logic [NID_W-1:0]   md_q, ms_q;
  logic [BLK_AW-1:0]  mb_q;

  coh_dir_store #(.N_NODES(N_NODES), .BLK_AW(BLK_AW)) i_store (
    .clk(clk), .rst(rst),
    .rd_addr(req_blk), .rd_state(rd_state), .rd_sharers(rd_sh),
    .we(dir_we), .wr_addr(dir_waddr), .wr_state(dir_wstate), .wr_sharers(dir_wsh)
  );

  coh_lowest_one #(.W(N_NODES), .IW(NID_W)) i_owner (.vec(rd_sh), .idx(owner_idx));
  coh_lowest_one #(.W(N_NODES), .IW(NID_W)) i_invpick (.vec(inv_mask), .idx(inv_idx));

  assign req_ready = (st == S_IDLE);
  assign acc       = req_valid && req_ready;
  assign ack_hit   = acc && req_type == RQ_IACK && pend && req_blk == pend_blk;
  assign reqbit    = {{(N_NODES-1){1'b0}}, 1'b1} << cur_src;
  assign others    = rd_sh & ~reqbit;
  assign is_exc    = (rd_state == DS_EXC);
  assign req_owns  = is_exc && rd_sh[cur_src];
  assign ack_load  = (st == S_LOOK) && cur_type == RQ_EXCL && others != '0;

  always_comb begin
    others_cnt = '0;
    for (int i = 0; i < N_NODES; i++) others_cnt = others_cnt + CNT_W'(others[i]);
  end

  coh_ack_counter #(.CW(CNT_W)) i_acks (
    .clk(clk), .rst(rst), .load(ack_load), .load_val(others_cnt),
    .dec(ack_hit), .last(ack_last)
  );

  // directory update: clearing sweep after reset, then one write per lookup
  always_comb begin
    dir_we     = 1'b0;
    dir_waddr  = cur_blk;
    dir_wstate = DS_INV;
    dir_wsh    = '0;
    if (st == S_INIT) begin
      dir_we    = 1'b1;
      dir_waddr = init_ptr;
    end else if (st == S_LOOK) begin
      case (cur_type)
        RQ_READ: if (!req_owns) begin
          dir_we     = 1'b1;
          dir_wstate = DS_SHR;
          dir_wsh    = rd_sh | reqbit;
        end
        RQ_EXCL: begin
          dir_we     = 1'b1;
          dir_wstate = DS_EXC;
          dir_wsh    = reqbit;
        end
        RQ_WBACK: if (req_owns) dir_we = 1'b1;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= S_INIT;
      init_ptr <= '0;
      cur_type <= '0;
      cur_src  <= '0;
      cur_blk  <= '0;
      pend     <= 1'b0;
      pend_src <= '0;
      pend_blk <= '0;
      inv_mask <= '0;
      mv_q     <= 1'b0;
      mt_q     <= '0;
      md_q     <= '0;
      ms_q     <= '0;
      mb_q     <= '0;
    end else begin
      case (st)
        S_INIT: begin
          init_ptr <= init_ptr + 1'b1;
          if (init_ptr == '1) st <= S_IDLE;
        end
        S_IDLE: if (acc) begin
          if (req_type == RQ_IACK) begin
            if (ack_hit && ack_last) begin
              pend <= 1'b0;
              mv_q <= 1'b1; mt_q <= MS_GRANT;
              md_q <= pend_src; ms_q <= pend_src; mb_q <= pend_blk;
              st   <= S_SEND;
            end
          end else if (pend && (req_blk == pend_blk || req_type == RQ_EXCL)) begin
            mv_q <= 1'b1; mt_q <= MS_BUSY;
            md_q <= req_src; ms_q <= req_src; mb_q <= req_blk;
            st   <= S_SEND;
          end else begin
            cur_type <= req_type;
            cur_src  <= req_src;
            cur_blk  <= req_blk;
            st       <= S_LOOK;
          end
        end
        S_LOOK: begin
          st   <= S_IDLE;
          ms_q <= cur_src;
          mb_q <= cur_blk;
          md_q <= cur_src;
          case (cur_type)
            RQ_READ: if (!req_owns) begin
              mv_q <= 1'b1;
              st   <= S_SEND;
              if (is_exc) begin
                mt_q <= MS_FWD;
                md_q <= owner_idx;
              end else begin
                mt_q <= MS_DATA;
              end
            end
            RQ_EXCL: if (others == '0) begin
              mv_q <= 1'b1; mt_q <= MS_GRANT;
              st   <= S_SEND;
            end else begin
              inv_mask <= others;
              pend     <= 1'b1;
              pend_src <= cur_src;
              pend_blk <= cur_blk;
              st       <= S_INVS;
            end
            default: ;
          endcase
        end
        S_SEND: if (msg_ready) begin
          mv_q <= 1'b0;
          st   <= S_IDLE;
        end
        S_INVS: if (!mv_q || msg_ready) begin
          if (inv_mask != '0) begin
            mv_q <= 1'b1; mt_q <= MS_INV;
            md_q <= inv_idx; ms_q <= pend_src; mb_q <= pend_blk;
            inv_mask <= inv_mask & ~({{(N_NODES-1){1'b0}}, 1'b1} << inv_idx);
          end else begin
            mv_q <= 1'b0;
            st   <= S_IDLE;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assign msg_valid = mv_q;
  assign msg_type  = mt_q;
  assign msg_dst   = md_q;
  assign msg_src   = ms_q;
  assign msg_blk   = mb_q;

  a_r9_msg_hold: assert property (@(posedge clk) disable iff (rst)
    (msg_valid && !msg_ready) |=> (msg_valid && $stable(msg_type) && $stable(msg_dst)
                                   && $stable(msg_src) && $stable(msg_blk)));
  a_r5_no_self_inv: assert property (@(posedge clk) disable iff (rst)
    (msg_valid && msg_type == MS_INV) |-> (msg_dst != msg_src));
  a_r7_busy_needs_lock: assert property (@(posedge clk) disable iff (rst)
    (msg_valid && msg_type == MS_BUSY) |-> pend);
  a_r6_grant_unlocked: assert property (@(posedge clk) disable iff (rst)
    (msg_valid && msg_type == MS_GRANT) |-> !pend);
  a_r9_ready_when_quiet: assert property (@(posedge clk) disable iff (rst)
    req_ready |-> !msg_valid);
endmodule

// File: tb/test_coh_dir_home.sv
module test_coh_dir_home;
  localparam int N  = 4;
  localparam int AW = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic req_valid = 1'b0;
  logic req_ready;
  logic [1:0] req_type = '0;
  logic [1:0] req_src = '0;
  logic [AW-1:0] req_blk = '0;
  logic msg_valid;
  logic msg_ready = 1'b0;
  logic [2:0] msg_type;
  logic [1:0] msg_dst, msg_src;
  logic [AW-1:0] msg_blk;

  always #5 clk = ~clk;

  coh_dir_home #(.N_NODES(N), .BLK_AW(AW)) i_coh_dir_home (
    .clk(clk), .rst(rst),
    .req_valid(req_valid), .req_ready(req_ready), .req_type(req_type),
    .req_src(req_src), .req_blk(req_blk),
    .msg_valid(msg_valid), .msg_ready(msg_ready), .msg_type(msg_type),
    .msg_dst(msg_dst), .msg_src(msg_src), .msg_blk(msg_blk)
  );

  int n_tests = 0;
  int n_fail  = 0;

  // requirement-level model
  logic [1:0]    m_st [1<<AW];
  logic [N-1:0]  m_sh [1<<AW];
  logic          m_pend = 1'b0;
  logic [1:0]    m_psrc = '0;
  logic [AW-1:0] m_pblk = '0;
  int            m_cnt = 0;
  logic [N-1:0]  m_ack = '0;

  logic [2:0]    e_type [8];
  logic [1:0]    e_dst [8], e_src [8];
  logic [AW-1:0] e_blk [8];
  int            e_n;
  logic [2:0]    g_type [8];
  logic [1:0]    g_dst [8], g_src [8];
  logic [AW-1:0] g_blk [8];
  int            g_n;

  task automatic check(input bit ok, input string tag, input string what,
                       input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic push(input logic [2:0] t, input logic [1:0] d, input logic [1:0] s,
                      input logic [AW-1:0] b);
    e_type[e_n] = t; e_dst[e_n] = d; e_src[e_n] = s; e_blk[e_n] = b;
    e_n++;
  endtask

  task automatic model_step(input logic [1:0] t, input logic [1:0] s, input logic [AW-1:0] b);
    logic [N-1:0] rb, oth;
    rb  = 4'b0001 << s;
    e_n = 0;
    if (t == 2'd3) begin
      if (m_pend && b == m_pblk) begin
        m_cnt--;
        m_ack[s] = 1'b0;
        if (m_cnt == 0) begin
          push(3'd3, m_psrc, m_psrc, b);
          m_pend = 1'b0;
        end
      end
    end else if (m_pend && (b == m_pblk || t == 2'd1)) begin
      push(3'd4, s, s, b);
    end else begin
      case (t)
        2'd0: begin
          if (m_st[b] == 2'd2 && m_sh[b][s]) begin
          end else begin
            if (m_st[b] == 2'd2) begin
              for (int i = N - 1; i >= 0; i--)
                if (m_sh[b][i]) oth = 4'(i);
              push(3'd1, oth[1:0], s, b);
            end else begin
              push(3'd0, s, s, b);
            end
            m_st[b] = 2'd1;
            m_sh[b] = m_sh[b] | rb;
          end
        end
        2'd1: begin
          oth = m_sh[b] & ~rb;
          m_st[b] = 2'd2;
          m_sh[b] = rb;
          if (oth == '0) push(3'd3, s, s, b);
          else begin
            m_cnt = 0;
            for (int i = 0; i < N; i++)
              if (oth[i]) begin
                push(3'd2, 2'(i), s, b);
                m_cnt++;
              end
            m_pend = 1'b1; m_psrc = s; m_pblk = b; m_ack = oth;
          end
        end
        default: begin
          if (m_st[b] == 2'd2 && m_sh[b][s]) begin
            m_st[b] = 2'd0;
            m_sh[b] = '0;
          end
        end
      endcase
    end
  endtask

  task automatic run_req(input logic [1:0] t, input logic [1:0] s, input logic [AW-1:0] b,
                         input string tag);
    int guard;
    logic pv, pr;
    logic [2:0] pt;
    logic [1:0] pd, ps;
    logic [AW-1:0] pb;
    model_step(t, s, b);
    g_n = 0;
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_type = t; req_src = s; req_blk = b;
    @(negedge clk);
    req_valid = 1'b0;
    guard = 0;
    pv = 1'b0; pr = 1'b0; pt = '0; pd = '0; ps = '0; pb = '0;
    forever begin
      if (pv && !pr) begin
        check(msg_valid && msg_type == pt && msg_dst == pd && msg_src == ps && msg_blk == pb,
              "R9", "held message fields", {msg_valid, msg_type, msg_dst}, {1'b1, pt, pd});
      end
      if (req_ready && !msg_valid) break;
      msg_ready = ($urandom % 4) != 0;
      if (msg_valid && msg_ready && g_n < 8) begin
        g_type[g_n] = msg_type; g_dst[g_n] = msg_dst;
        g_src[g_n] = msg_src; g_blk[g_n] = msg_blk;
        g_n++;
      end
      pv = msg_valid; pr = msg_ready; pt = msg_type; pd = msg_dst; ps = msg_src; pb = msg_blk;
      guard++;
      if (guard > 1000) begin
        check(1'b0, tag, "response never completed", guard, 1000);
        break;
      end
      @(negedge clk);
    end
    msg_ready = 1'b0;
    check(g_n == e_n, tag, "message count", g_n, e_n);
    for (int i = 0; i < e_n && i < g_n; i++) begin
      check(g_type[i] == e_type[i], tag, "msg_type", g_type[i], e_type[i]);
      check(g_dst[i] == e_dst[i], tag, "msg_dst", g_dst[i], e_dst[i]);
      check(g_src[i] == e_src[i], tag, "msg_src", g_src[i], e_src[i]);
      check(g_blk[i] == e_blk[i], tag, "msg_blk", g_blk[i], e_blk[i]);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    n_tests++;
    $display("FAIL watchdog R9 actual=running expected=finished");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    int wait_cyc;
    void'($urandom(32'd4711));
    for (int i = 0; i < (1 << AW); i++) begin
      m_st[i] = 2'd0;
      m_sh[i] = '0;
    end
    repeat (3) @(negedge clk);
    // R1: quiet during reset
    check(!msg_valid && !req_ready, "R1", "outputs in reset", {msg_valid, req_ready}, 0);
    rst = 1'b0;
    wait_cyc = 0;
    while (!req_ready && wait_cyc < 100) begin
      @(negedge clk);
      wait_cyc++;
    end
    check(wait_cyc <= (1 << AW) + 3, "R1", "cycles until ready", wait_cyc, (1 << AW) + 3);
    check(!msg_valid, "R1", "msg_valid after clear", msg_valid, 0);
    run_req(2'd0, 2'd3, 4'd9, "R1");

    // R2: reads to Invalid then Shared
    run_req(2'd0, 2'd0, 4'd0, "R2");
    run_req(2'd0, 2'd1, 4'd0, "R2");
    // R5: ownership with two other sharers
    run_req(2'd1, 2'd2, 4'd0, "R5");
    // R7: locked window
    run_req(2'd0, 2'd3, 4'd0, "R7");
    run_req(2'd1, 2'd3, 4'd5, "R7");
    run_req(2'd3, 2'd0, 4'd7, "R7");
    run_req(2'd0, 2'd3, 4'd5, "R7");
    // R6: grant only after the last acknowledgement
    run_req(2'd3, 2'd0, 4'd0, "R6");
    run_req(2'd3, 2'd1, 4'd0, "R6");
    // R4 and R3
    run_req(2'd0, 2'd2, 4'd0, "R4");
    run_req(2'd0, 2'd1, 4'd0, "R3");
    run_req(2'd0, 2'd0, 4'd0, "R2");
    // R5: requester is itself a sharer
    run_req(2'd1, 2'd1, 4'd0, "R5");
    run_req(2'd3, 2'd2, 4'd0, "R6");
    run_req(2'd3, 2'd0, 4'd0, "R6");
    // R8: writebacks
    run_req(2'd2, 2'd3, 4'd0, "R8");
    run_req(2'd0, 2'd1, 4'd0, "R8");
    run_req(2'd2, 2'd1, 4'd0, "R8");
    run_req(2'd1, 2'd0, 4'd0, "R8");
    // R6: immediate grant on an untouched block
    run_req(2'd1, 2'd3, 4'd1, "R6");

    // random mix over four blocks
    for (int k = 0; k < 600; k++) begin
      if (m_pend && m_ack != '0 && ($urandom % 2) == 0) begin
        int n0;
        n0 = int'($urandom % 4);
        while (!m_ack[n0[1:0]]) n0 = (n0 + 1) % 4;
        run_req(2'd3, n0[1:0], m_pblk, "R6");
      end else begin
        logic [1:0] rt;
        rt = 2'($urandom % 3);
        if (($urandom % 20) == 0) rt = 2'd3;
        run_req(rt, 2'($urandom), 4'($urandom % 4), "R7");
      end
    end
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule